// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block tracks the row-buffer state of one DRAM bank and turns each accepted read or write request into the shortest legal series of bank commands. It compares the requested row with the row held open in the bank. A request to the open row is a hit, a request to an idle bank is a miss, and a request to a different row while one is open is a conflict. From that result it emits the precharge, activate and column commands in order. Per-bank down-counters hold each command back until its minimum spacing has elapsed.

Every request moves one whole block as a burst of column accesses on consecutive cycles, all to the same row. A static policy input selects how the row buffer is managed. In open-row mode the row stays open after the burst. In closed-row mode the bank precharges after the burst, unless a lookahead hint reports that a queued request still wants the same row.

The request port uses a valid/ready handshake and takes one request at a time. The command port issues at most one command per cycle.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset the bank holds no open row, `req_ready_o` is 1 and `cmd_valid_o` is 0. The first request after reset is therefore issued as an activate with no precharge in front of it.
- R2: Command encoding is as follows: `cmd_op_o` is 1 for precharge, 2 for activate, 3 for read and 4 for write. For activate, `cmd_addr_o` carries the row. For read and write it carries the column. For precharge it carries 0. A request whose row equals the open row issues only column commands.
- R3: In open-row mode, a request to a row other than the open one issues a precharge, then an activate of the new row, then the column burst. After any burst in open-row mode the row stays open.
- R4: In closed-row mode, a request to an idle bank issues an activate, then the column burst, then a precharge. The precharge comes in the cycle after the last column command.
- R5: In closed-row mode, if `keep_open_i` is 1 in the cycle of the last column command, no precharge is issued and the row stays open. The next request to that row then issues only column commands.
- R6: Two activate commands are at least T_RC cycles apart.
- R7: An activate comes at least T_RP cycles after the preceding precharge.
- R8: The first column command of a burst comes at least T_RCD cycles after the activate that opened its row.
- R9: A read command comes at least T_WTR cycles after the most recent write command.
- R10: A request issues BURST_LEN column commands on consecutive cycles. All of them are reads if `req_we_i` is 0, and all are writes if it is 1. Beat i addresses column `{col[hi:log2(BURST_LEN)], (col + i) mod BURST_LEN}`, so the burst starts at the requested column and wraps inside the aligned block.
- R11: `req_ready_o` is 1 only while the sequencer is idle, and no command is issued in that state. A request is accepted only on a cycle where `req_valid_i` and `req_ready_o` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| closed_row_i | input | 1 | Row policy select: 1 for closed-row, 0 for open-row. Changed only while idle |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle and able to accept a request |
| req_row_i | input | ROW_W | Requested row |
| req_col_i | input | COL_W | Requested starting column |
| req_we_i | input | 1 | 1 for a write request, 0 for a read request |
| keep_open_i | input | 1 | Lookahead hint that a queued request targets the same row |
| cmd_valid_o | output | 1 | A command is issued this cycle |
| cmd_op_o | output | 3 | Command opcode |
| cmd_addr_o | output | max(ROW_W,COL_W) | Row or column address of the command |

## Verification
The hardest case to reach is the one where several spacing rules bind on the same command. Examples are an activate held by T_RC right after a closed-row precharge, and a read burst held by T_WTR directly behind a write to the same open row. A random row pool drives the stimulus. The pool holds only four rows, so hits, conflicts and back-to-back activates all occur often, and the policy and hint toggle at random between requests. Directed sequences place a write followed by a same-row read, and a kept-open row followed by a request to a different row.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_PRE = 3'd1,
    OP_ACT = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    ACC_HIT,
    ACC_MISS,
    ACC_CONFLICT
  } access_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_COL,
    S_CLOSE
  } seq_state_e;
endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int unsigned T_MIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned W = (T_MIN > 1) ? $clog2(T_MIN) : 1;
  localparam logic [W-1:0] LOAD_VAL = (T_MIN > 0) ? W'(T_MIN - 1) : '0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/row_classifier.sv
module row_classifier
  import bank_seq_pkg::*;
#(
  parameter int unsigned ROW_W = 14
) (
  input  logic             open_vld_i,
  input  logic [ROW_W-1:0] open_row_i,
  input  logic [ROW_W-1:0] req_row_i,
  output access_e          kind_o
);
  always_comb begin
    if (!open_vld_i)                  kind_o = ACC_MISS;
    else if (open_row_i == req_row_i) kind_o = ACC_HIT;
    else                              kind_o = ACC_CONFLICT;
  end
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int unsigned ROW_W     = 14,
  parameter int unsigned COL_W     = 11,
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned T_RC      = 20,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_WTR     = 4,
  localparam int unsigned ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              closed_row_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_we_i,
  input  logic              keep_open_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  seq_state_e       state_q, state_d;
  access_e          kind;
  logic             open_vld_q;
  logic [ROW_W-1:0] open_row_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             we_q;
  logic [BEAT_W-1:0] beat_q;

  logic rc_ok, rcd_ok, rp_ok, wtr_ok;
  logic issue_pre, issue_act, issue_col, last_col;

  row_classifier #(.ROW_W(ROW_W)) i_classifier (
    .open_vld_i (open_vld_q),
    .open_row_i (open_row_q),
    .req_row_i  (req_row_i),
    .kind_o     (kind)
  );

  // Spacing timers: activate-activate, activate-column, precharge-activate, write-read
  bank_timer #(.T_MIN(T_RC))  i_rc_timer  (.clk_i, .rst_ni, .load_i(issue_act), .done_o(rc_ok));
  bank_timer #(.T_MIN(T_RCD)) i_rcd_timer (.clk_i, .rst_ni, .load_i(issue_act), .done_o(rcd_ok));
  bank_timer #(.T_MIN(T_RP))  i_rp_timer  (.clk_i, .rst_ni, .load_i(issue_pre), .done_o(rp_ok));
  bank_timer #(.T_MIN(T_WTR)) i_wtr_timer (.clk_i, .rst_ni,
                                           .load_i(issue_col && we_q), .done_o(wtr_ok));

  assign req_ready_o = (state_q == S_IDLE);
  assign issue_pre   = (state_q == S_PRE) || (state_q == S_CLOSE);
  assign issue_act   = (state_q == S_ACT) && rc_ok && rp_ok;
  assign issue_col   = (state_q == S_COL) && rcd_ok && (we_q || wtr_ok);
  assign last_col    = issue_col && (beat_q == LAST_BEAT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req_valid_i) begin
        unique case (kind)
          ACC_HIT:      state_d = S_COL;
          ACC_MISS:     state_d = S_ACT;
          default:      state_d = S_PRE;
        endcase
      end
      S_PRE:   state_d = S_ACT;
      S_ACT:   if (issue_act) state_d = S_COL;
      S_COL:   if (last_col) state_d = (closed_row_i && !keep_open_i) ? S_CLOSE : S_IDLE;
      S_CLOSE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      open_vld_q <= 1'b0;
      open_row_q <= '0;
      row_q      <= '0;
      col_q      <= '0;
      we_q       <= 1'b0;
      beat_q     <= '0;
    end else begin
      state_q <= state_d;
      if (req_ready_o && req_valid_i) begin
        row_q  <= req_row_i;
        col_q  <= req_col_i;
        we_q   <= req_we_i;
        beat_q <= '0;
      end
      if (issue_col) beat_q <= beat_q + 1'b1;
      if (issue_act) begin
        open_vld_q <= 1'b1;
        open_row_q <= row_q;
      end else if (issue_pre) begin
        open_vld_q <= 1'b0;
      end
    end
  end

  logic [COL_W-1:0] beat_col;
  always_comb begin
    beat_col = col_q;
    beat_col[BEAT_W-1:0] = col_q[BEAT_W-1:0] + beat_q;
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_NOP;
    cmd_addr_o  = '0;
    if (issue_pre) begin
      cmd_valid_o = 1'b1;
      cmd_op_o    = OP_PRE;
    end else if (issue_act) begin
      cmd_valid_o = 1'b1;
      cmd_op_o    = OP_ACT;
      cmd_addr_o  = ADDR_W'(row_q);
    end else if (issue_col) begin
      cmd_valid_o = 1'b1;
      cmd_op_o    = we_q ? OP_WR : OP_RD;
      cmd_addr_o  = ADDR_W'(beat_col);
    end
  end

  // Assertion support: cycles elapsed since the last activate / precharge (saturating)
  localparam int unsigned GAP_W = $clog2(T_RC + T_RP + 2) + 1;
  logic [GAP_W-1:0] since_act_q, since_pre_q;
  logic cmd_is_act, cmd_is_pre, cmd_is_col;
  assign cmd_is_act = cmd_valid_o && (cmd_op_o == OP_ACT);
  assign cmd_is_pre = cmd_valid_o && (cmd_op_o == OP_PRE);
  assign cmd_is_col = cmd_valid_o && ((cmd_op_o == OP_RD) || (cmd_op_o == OP_WR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= '1;
      since_pre_q <= '1;
    end else begin
      if (cmd_is_act)              since_act_q <= GAP_W'(1);
      else if (since_act_q != '1)  since_act_q <= since_act_q + 1'b1;
      if (cmd_is_pre)              since_pre_q <= GAP_W'(1);
      else if (since_pre_q != '1)  since_pre_q <= since_pre_q + 1'b1;
    end
  end

  AST_ACT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_is_act |-> since_act_q >= GAP_W'(T_RC)); // R6
  AST_PRE_TO_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_is_act |-> since_pre_q >= GAP_W'(T_RP)); // R7
  AST_ACT_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_is_act |-> !open_vld_q); // R3
  AST_COL_NEEDS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_is_col |-> open_vld_q); // R2
  AST_BURST_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_is_col && beat_q != LAST_BEAT) |=> (cmd_valid_o && cmd_op_o == $past(cmd_op_o))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !cmd_valid_o); // R11
endmodule

// File: tb/test_bank_cmd_seq.sv
module test_bank_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 14, COL_W = 11, BL = 8;
  localparam int T_RC = 20, T_RCD = 3, T_RP = 3, T_WTR = 4;
  localparam int ADDR_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic closed_row = 1'b0, req_valid = 1'b0, req_we = 1'b0, keep_open = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, cmd_valid;
  logic [2:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BL), .T_RC(T_RC),
                 .T_RCD(T_RCD), .T_RP(T_RP), .T_WTR(T_WTR)) i_bank_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .closed_row_i(closed_row),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_row_i(req_row),
    .req_col_i(req_col), .req_we_i(req_we), .keep_open_i(keep_open),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_addr_o(cmd_addr));

  int n_checks = 0, n_fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench model of the bank
  bit exp_open = 0;
  int exp_row = 0;
  int last_act = -1000, last_pre = -1000, last_wr = -1000;

  function automatic int beat_col(int col, int i);
    return (col & ~(BL - 1)) | ((col + i) & (BL - 1));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_req(int row, int col, bit we, bit hint, bit closed);
    int e_op[16]; int e_addr[16]; int e_n = 0;
    int g_op[16]; int g_addr[16]; int g_cyc[16]; int g_n = 0;
    int act_cyc = -1000;
    string tag;
    // expected sequence
    if (exp_open && exp_row == row) tag = "R2";
    else if (exp_open) begin
      tag = "R3";
      e_op[e_n] = 1; e_addr[e_n] = 0; e_n++;
      e_op[e_n] = 2; e_addr[e_n] = row; e_n++;
    end else begin
      tag = closed ? "R4" : "R1";
      e_op[e_n] = 2; e_addr[e_n] = row; e_n++;
    end
    for (int i = 0; i < BL; i++) begin
      e_op[e_n] = we ? 4 : 3; e_addr[e_n] = beat_col(col, i); e_n++;
    end
    if (closed && !hint) begin
      e_op[e_n] = 1; e_addr[e_n] = 0; e_n++;
      exp_open = 0;
      if (tag == "R2") tag = "R5";
    end else begin
      exp_open = 1; exp_row = row;
    end
    // drive
    @(negedge clk);
    closed_row = closed; keep_open = hint;
    check(req_ready == 1'b1, "R11", req_ready, 1);
    req_valid = 1'b1; req_row = ROW_W'(row); req_col = COL_W'(col); req_we = we;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (cmd_valid && g_n < 16) begin
        g_op[g_n] = int'(cmd_op); g_addr[g_n] = int'(cmd_addr); g_cyc[g_n] = cyc; g_n++;
        if (req_ready) check(0, "R11", 1, 0);
      end
      if (req_ready) break;
      @(negedge clk);
      if (k == 299) check(0, "R11 watchdog", k, 0);
    end
    check(g_n == e_n, tag, g_n, e_n);
    for (int i = 0; i < g_n && i < e_n; i++) begin
      check(g_op[i] == e_op[i], (i >= e_n - BL - ((closed && !hint) ? 1 : 0) && e_op[i] > 2) ? "R10" : tag,
            g_op[i], e_op[i]);
      check(g_addr[i] == e_addr[i], (e_op[i] > 2) ? "R10" : "R2", g_addr[i], e_addr[i]);
    end
    // timing
    for (int i = 0; i < g_n; i++) begin
      case (g_op[i])
        1: last_pre = g_cyc[i];
        2: begin
          check(g_cyc[i] - last_act >= T_RC, "R6", g_cyc[i] - last_act, T_RC);
          check(g_cyc[i] - last_pre >= T_RP, "R7", g_cyc[i] - last_pre, T_RP);
          last_act = g_cyc[i]; act_cyc = g_cyc[i];
        end
        3, 4: begin
          if (i > 0 && g_op[i-1] == g_op[i])
            check(g_cyc[i] == g_cyc[i-1] + 1, "R10", g_cyc[i] - g_cyc[i-1], 1);
          else
            check(g_cyc[i] - last_act >= T_RCD, "R8", g_cyc[i] - last_act, T_RCD);
          if (g_op[i] == 3)
            check(g_cyc[i] - last_wr >= T_WTR, "R9", g_cyc[i] - last_wr, T_WTR);
          else last_wr = g_cyc[i];
        end
        default: check(0, "R2", g_op[i], 1);
      endcase
      if (i + 1 < g_n && g_op[i+1] == 1 && g_op[i] > 2)
        check(g_cyc[i+1] == g_cyc[i] + 1, "R4", g_cyc[i+1] - g_cyc[i], 1);
    end
    if (act_cyc > -1000) check(1, "R8", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4471);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", req_ready, 1);
    check(cmd_valid == 1'b0, "R1", cmd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R1", cmd_valid, 0);
    // directed: miss after reset, write then read hit (R9), conflict (R3)
    do_req(5, 3, 1, 0, 0);
    do_req(5, 6, 0, 0, 0);
    do_req(9, 0, 0, 0, 0);
    // closed-row: close after burst (R4), hint keeps row (R5), wrong hint row (R3)
    do_req(2, 7, 0, 0, 1);
    do_req(2, 1, 1, 1, 1);
    do_req(2, 4, 0, 0, 1);
    do_req(3, 0, 1, 1, 1);
    do_req(4, 2, 0, 0, 1);
    // random mix
    for (int n = 0; n < 300; n++) begin
      do_req(int'($urandom_range(0, 3)) * 1000 + 7, int'($urandom_range(0, 2047)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule